// File: doc/BRIEF.md
# Processor Status Flags Register

This block holds the 16-bit status word of a small processor core. After an 8-bit or 16-bit add or subtract, the execution stage presents the two operands, the result, a width select and an operation select, and pulses an update strobe. The register then captures six condition bits: carry or borrow, parity, nibble carry, zero, sign and signed overflow. Three control bits sit in the same word: single-step trap, interrupt enable and string direction. Software changes them only through dedicated set and clear commands. Unused positions always read as zero.

The condition bits are computed from the operands for the carry-type flags and from the result for the value-type flags. All of them land in the register on the clock edge at which the strobe is high. The whole word is a registered output, so downstream branch and interrupt logic sees stable values for a full cycle.

Top module: `cpu_status_reg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the flag word reads 16'h0000.
- R2: Bit 0 (carry) captures the carry out of the selected width for an add (op_sub=0), and the borrow (minuend less than subtrahend, unsigned, in the selected width) for a subtract (op_sub=1).
- R3: Bit 2 (parity) captures 1 when the low 8 bits of the result contain an even number of ones, and 0 otherwise, in either width.
- R4: Bit 4 (nibble carry) captures the carry out of bit 3 of the operand sum for an add, and the borrow into bit 4 (low nibble of minuend less than that of subtrahend) for a subtract.
- R5: Bit 6 (zero) captures 1 when the result is zero and bit 7 (sign) captures its top bit, where the width is 16 bits when wide=1 and the low 8 bits (sign taken from bit 7, upper result byte ignored) when wide=0.
- R6: Bit 11 (overflow) captures, for an add, operands of equal sign with a result of different sign; for a subtract, operands of differing sign with a result whose sign differs from the minuend; using the sign bit of the selected width.
- R7: The condition bits change only at a clock edge where upd=1 and are visible in the following cycle; with upd=0 they hold.
- R8: Bit 8 (trap), bit 9 (interrupt enable) and bit 10 (direction) are each set by their set command and cleared by their clear command on the next edge; when both commands of one bit are high, clear wins; with neither, the bit holds.
- R9: An arithmetic update never changes bits 8 to 10, and control commands never change the condition bits.
- R10: Bits 1, 3, 5 and 12 to 15 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand (subtrahend for subtract) |
| alu_res | input | 16 | Result produced by the ALU |
| wide | input | 1 | 1 selects 16-bit flags, 0 selects 8-bit flags |
| op_sub | input | 1 | 1 for subtract, 0 for add |
| upd | input | 1 | Capture the condition bits at this edge |
| trap_set | input | 1 | Set the trap bit |
| trap_clr | input | 1 | Clear the trap bit |
| ie_set | input | 1 | Set the interrupt-enable bit |
| ie_clr | input | 1 | Clear the interrupt-enable bit |
| dir_set | input | 1 | Set the direction bit |
| dir_clr | input | 1 | Clear the direction bit |
| flags | output | 16 | Registered status word |

## Verification
Every bit of the internal state is itself a port bit, so a wrong condition or control bit shows on the flag word exactly one cycle after the edge that wrote it, and a bit that drifts without a strobe or command shows in the cycle it moves. The subtle failures are width mix-ups: a carry or sign taken from the wrong bit in byte mode, or a zero test that looks at the ignored upper byte, only surface with operands whose upper bytes disagree with the low ones. Borrow direction and the clear-over-set priority likewise need targeted patterns rather than plain sums.

// File: rtl/status_pkg.sv
package status_pkg;

  localparam int CY_POS = 0;
  localparam int PE_POS = 2;
  localparam int NC_POS = 4;
  localparam int ZR_POS = 6;
  localparam int NG_POS = 7;
  localparam int TR_POS = 8;
  localparam int OV_POS = 11;
  localparam int N_CTRL = 3;

  typedef struct packed {
    logic cy;
    logic pe;
    logic nc;
    logic zr;
    logic ng;
    logic ov;
  } cond_flags_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb,
                                      input logic sr, input logic sub);
    if (sub) return (sa != sb) && (sr != sa);
    else     return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/status_cond.sv
module status_cond #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [DW-1:0]            a,
  input  logic [DW-1:0]            b,
  input  logic [DW-1:0]            r,
  input  logic                     wide,
  input  logic                     sub,
  output status_pkg::cond_flags_t  fl
);
  localparam int NIB = 4;

  logic [DW:0]  full_w;
  logic [NW:0]  part_w;
  logic [NIB:0] nib_w;
  logic         sa, sb, sr;

  always_comb begin
    if (sub) begin
      full_w = {1'b0, a} - {1'b0, b};
      part_w = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]};
      nib_w  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
    end else begin
      full_w = {1'b0, a} + {1'b0, b};
      part_w = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
      nib_w  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
    end
    sa = wide ? a[DW-1] : a[NW-1];
    sb = wide ? b[DW-1] : b[NW-1];
    sr = wide ? r[DW-1] : r[NW-1];
    fl.cy = wide ? full_w[DW] : part_w[NW];
    fl.nc = nib_w[NIB];
    fl.pe = status_pkg::even_ones8(r[7:0]);
    fl.zr = wide ? (r == '0) : (r[NW-1:0] == '0);
    fl.ng = sr;
    fl.ov = status_pkg::signed_ovf(sa, sb, sr, sub);
  end
endmodule

// File: rtl/status_ctrl_bit.sv
module status_ctrl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] alu_res,
  input  logic          wide,
  input  logic          op_sub,
  input  logic          upd,
  input  logic          trap_set,
  input  logic          trap_clr,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          dir_set,
  input  logic          dir_clr,
  output logic [15:0]   flags
);
  import status_pkg::*;

  cond_flags_t       cond_next;
  cond_flags_t       cond_q;
  logic              cond_wr;
  logic [N_CTRL-1:0] ctrl_set;
  logic [N_CTRL-1:0] ctrl_clr;
  logic [N_CTRL-1:0] ctrl_q;
  logic [15:0]       word_w;

  assign cond_wr  = upd;
  assign ctrl_set = {dir_set, ie_set, trap_set};
  assign ctrl_clr = {dir_clr, ie_clr, trap_clr};

  status_cond #(.DW(DW), .NW(NW)) u_cond (
    .a(opnd_a), .b(opnd_b), .r(alu_res),
    .wide(wide), .sub(op_sub), .fl(cond_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cond_q <= '0;
    else if (cond_wr) cond_q <= cond_next;
  end

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    status_ctrl_bit u_bit (
      .clk(clk), .rst_n(rst_n),
      .set_i(ctrl_set[i]), .clr_i(ctrl_clr[i]), .q(ctrl_q[i])
    );
  end

  always_comb begin
    word_w         = '0;
    word_w[CY_POS] = cond_q.cy;
    word_w[PE_POS] = cond_q.pe;
    word_w[NC_POS] = cond_q.nc;
    word_w[ZR_POS] = cond_q.zr;
    word_w[NG_POS] = cond_q.ng;
    word_w[OV_POS] = cond_q.ov;
    for (int i = 0; i < N_CTRL; i++) word_w[TR_POS+i] = ctrl_q[i];
  end

  assign flags = word_w;
endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cond_wr,
  input logic [2:0]  ctrl_set,
  input logic [2:0]  ctrl_clr,
  input logic [15:0] alu_res,
  input logic        wide,
  input logic [15:0] flags
);
  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0000);

  // R7
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_wr |=> $stable({flags[11], flags[7:6], flags[4], flags[2], flags[0]}));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_set == 3'b000 && ctrl_clr == 3'b000) |=> $stable(flags[10:8]));

  // R8
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr[1] |=> !flags[9]);

  // R8
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_set[1] && !ctrl_clr[1]) |=> flags[9]);

  // R8
  dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr[2] |=> !flags[10]);

  // R5
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wr && wide && alu_res == 16'h0000) |=> (flags[6] && !flags[7]));

  // R5
  zero_sign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[6] && flags[7]));
endmodule

bind cpu_status_reg status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cond_wr(cond_wr),
  .ctrl_set(ctrl_set), .ctrl_clr(ctrl_clr),
  .alu_res(alu_res), .wide(wide), .flags(flags)
);

// File: tb/cpu_status_reg_test.sv
module cpu_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
  logic        wide = 1'b0, op_sub = 1'b0, upd = 1'b0;
  logic        trap_set = 0, trap_clr = 0, ie_set = 0, ie_clr = 0;
  logic        dir_set = 0, dir_clr = 0;
  logic [15:0] flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] exp_q = 16'h0000;

  always #10 clk = ~clk;

  cpu_status_reg uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_res(alu_res), .wide(wide), .op_sub(op_sub), .upd(upd),
    .trap_set(trap_set), .trap_clr(trap_clr), .ie_set(ie_set),
    .ie_clr(ie_clr), .dir_set(dir_set), .dir_clr(dir_clr), .flags(flags)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R2 carry", flags[0], exp_q[0]);
    cmp("R3 parity", flags[2], exp_q[2]);
    cmp("R4 nibble carry", flags[4], exp_q[4]);
    cmp("R5 zero", flags[6], exp_q[6]);
    cmp("R5 sign", flags[7], exp_q[7]);
    cmp("R6 overflow", flags[11], exp_q[11]);
    cmp("R8 control bits", flags[10:8], exp_q[10:8]);
    cmp("R10 undefined bits", flags & 16'hF02A, 0);
  endtask

  // Reference model: next flag word from the current word and the inputs.
  function automatic logic [15:0] model(input logic [15:0] cur,
      input int a, input int b, input int r, input bit w, input bit s,
      input bit u, input bit [5:0] cmd);
    logic [15:0] nx = cur;
    int width = w ? 16 : 8;
    int lim = (1 << width) - 1;
    int ua = a & lim, ub = b & lim, ur = r & lim;
    int top = width - 1;
    int ones = 0;
    bit sa = (ua >> top) & 1, sb = (ub >> top) & 1, sr = (ur >> top) & 1;
    if (u) begin
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      nx[0]  = s ? (ua < ub) : ((ua + ub) > lim);
      nx[2]  = (ones % 2) == 0;
      nx[4]  = s ? ((a & 15) < (b & 15)) : (((a & 15) + (b & 15)) > 15);
      nx[6]  = (ur == 0);
      nx[7]  = sr;
      nx[11] = s ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    end
    for (int i = 0; i < 3; i++) begin
      if (cmd[2*i+1])    nx[8+i] = 1'b0;
      else if (cmd[2*i]) nx[8+i] = 1'b1;
    end
    return nx;
  endfunction

  // cmd bits: {dir_clr, dir_set, ie_clr, ie_set, trap_clr, trap_set}
  task automatic step(input int a, input int b, input int r, input bit w,
                      input bit s, input bit u, input bit [5:0] cmd);
    opnd_a = a[15:0]; opnd_b = b[15:0]; alu_res = r[15:0];
    wide = w; op_sub = s; upd = u;
    {dir_clr, dir_set, ie_clr, ie_set, trap_clr, trap_set} = cmd;
    exp_q = model(exp_q, a, b, r, w, s, u, cmd);
    @(negedge clk);
    compare_all();
  endtask

  task automatic op(input int a, input int b, input bit w, input bit s);
    int r = s ? (a - b) : (a + b);
    step(a, b, r, w, s, 1'b1, 6'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset value while reset is asserted
    cmp("R1 reset", flags, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", flags, 16'h0000);

    // R2 R5 R6 word carry to zero: FFFF + 0001
    op(16'hFFFF, 16'h0001, 1, 0);
    cmp("R2 R5 FFFF+1", flags[11:0] & 12'h8D5, 12'h055);
    // R6 signed overflow 7FFF + 0001
    op(16'h7FFF, 16'h0001, 1, 0);
    cmp("R6 7FFF+1", flags[11] & flags[7], 1);
    // R2 R4 borrow: 0003 - 0005
    op(16'h0003, 16'h0005, 1, 1);
    cmp("R2 R4 borrow", {flags[4], flags[0]}, 2'b11);
    // R6 subtract overflow 8000 - 0001
    op(16'h8000, 16'h0001, 1, 1);
    cmp("R6 8000-1", flags[11], 1);
    // R5 byte mode: upper byte nonzero, low byte zero
    step(16'h12FF, 16'h3401, 16'h4700, 0, 0, 1, 6'b0);
    cmp("R5 byte zero", {flags[6], flags[0]}, 2'b11);
    // R5 byte sign from bit 7 while bit 15 clear
    step(16'h0070, 16'h0010, 16'h0080, 0, 0, 1, 6'b0);
    cmp("R5 R6 byte sign", {flags[11], flags[7]}, 2'b11);
    // R3 parity of 0x03 (even) and 0x07 (odd)
    step(0, 0, 16'hFF03, 1, 0, 1, 6'b0);
    cmp("R3 even", flags[2], 1);
    step(0, 0, 16'h0007, 1, 0, 1, 6'b0);
    cmp("R3 odd", flags[2], 0);
    // R4 nibble carry 000F + 0001
    op(16'h000F, 16'h0001, 0, 0);
    cmp("R4 nibble", flags[4], 1);
    // R7 strobe low: new operands ignored
    step(16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 6'b0);
    cmp("R7 hold", flags[4], 1);
    // R8 set all control bits, R9 condition bits unchanged
    step(0, 0, 0, 1, 0, 0, 6'b010101);
    cmp("R8 set all", flags[10:8], 3'b111);
    // R9 arithmetic update leaves control bits
    op(16'h0001, 16'h0001, 1, 0);
    cmp("R9 ctrl kept", flags[10:8], 3'b111);
    // R8 clear wins over set
    step(0, 0, 0, 1, 0, 0, 6'b111111);
    cmp("R8 clear wins", flags[10:8], 3'b000);

    // randomized run compared each cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int a = $urandom & 16'hFFFF;
      int b = $urandom & 16'hFFFF;
      bit s = $urandom_range(0, 1);
      int r = ($urandom_range(0, 7) == 0) ? ($urandom & 16'hFFFF)
              : (s ? (a - b) : (a + b));
      bit [5:0] cmd = '0;
      if ($urandom_range(0, 3) == 0) cmd = $urandom & 6'h3F;
      if ($urandom_range(0, 9) == 0) begin a = a & 16'hFF00; b = 0; r = a; end
      step(a, b, r, $urandom_range(0, 1), s, $urandom_range(0, 3) != 0, cmd);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule